// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture Unit

This block time-stamps external events. A 16-bit free-running count advances once every `PRESCALE` bus clocks. Each of two capture pins passes through a two-stage synchronizer and an edge detector. A valid edge on a pin copies the count, plus one, into that channel's capture register. It also raises that channel's status flag.

The CPU reaches the block over an 8-bit register interface. The interface has a byte address, a read strobe, a write strobe and a read-data bus. Each 16-bit capture register is read as a high byte and then a low byte. Once the high byte has been read, the channel holds still until its low byte is read, so the two bytes always belong to the same event. One shared enable bit decides whether a set flag drives the level-high interrupt request.

Top module: `tcap_unit`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the status register (address 1) reads 0, `irq` is low, and neither channel is blocked.
- R2: The internal count starts at 0 on reset and increments once every `PRESCALE` (default 4) clock cycles.
- R3: A capture loads the count value held in the cycle before the loading edge, plus one. The loading edge is the third rising clock edge after the pin changes. Channel 0's value reads at addresses 2 (bits 15:8) and 3 (bits 7:0). Channel 1's value reads at addresses 4 and 5.
- R4: Control bit 1 (channel 0) and control bit 2 (channel 1) select the capture edge: 1 selects rising and 0 selects falling. A transition of the other polarity causes no capture. Writing address 0 sets bit 0 (interrupt enable) and bits 2:1, and these bits read back as written.
- R5: A capture sets the channel's status flag: bit 0 for channel 0 and bit 1 for channel 1. `irq` is high exactly when control bit 0 is set and at least one flag is set.
- R6: A capture loads the register even when the channel's flag is already set, so the register holds the latest event.
- R7: Reading the high byte blocks that channel. An edge arriving while the channel is blocked, or in the same cycle as the high-byte read, is dropped and sets no flag. Reading the low byte unblocks the channel.
- R8: A flag clears when the status register is read while that flag is set and the channel's low byte is read afterwards. A capture in the same cycle wins over the clear.
- R9: Writes to addresses 2 to 5 have no effect. Reset does not change the capture registers.
- R10: The two channels are independent. An edge on one channel never changes the other channel's register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 2 | Asynchronous capture inputs; bit 0 is channel 0 |
| bus_addr | input | 3 | Register byte address |
| bus_rd | input | 1 | Read strobe; read side effects occur at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Level-high interrupt request |

## Verification
Several properties are checked on every cycle: a blocked channel never changes its register, a register only changes after a detected edge, a flag only rises after a capture was taken, and the interrupt stays low while it is disabled. Only the scenarios show the things that depend on time: the exact captured values, the three-edge latency and the count rate. They also show edge polarity, overwrite under a set flag, dropping while blocked, the two-step flag clear and retention across reset.

// File: rtl/tcap_unit.sv
module tcap_unit #(
  parameter int PRESCALE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cap_pin,
  input  logic [2:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] pre;
  logic [15:0]   tcnt;
  logic          ie;
  logic [1:0]    rise_sel;
  logic [1:0]    s1, s2, sp;
  logic [1:0]    det, take, flag, lock, arm;
  logic [1:0]    rd_hi, rd_lo;
  logic          rd_st;
  logic [15:0]   cap [2];
  logic          unused_wbits;

  assign unused_wbits = ^bus_wdata[7:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      tcnt <= '0;
    end else if (pre == PW'(PRESCALE - 1)) begin
      pre  <= '0;
      tcnt <= tcnt + 16'd1;
    end else begin
      pre <= pre + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie       <= 1'b0;
      rise_sel <= 2'b00;
    end else if (bus_wr && bus_addr == 3'd0) begin
      ie       <= bus_wdata[0];
      rise_sel <= bus_wdata[2:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      sp <= '0;
    end else begin
      s1 <= cap_pin;
      s2 <= s1;
      sp <= s2;
    end
  end

  assign det   = (rise_sel & s2 & ~sp) | (~rise_sel & ~s2 & sp);
  assign rd_st = bus_rd && bus_addr == 3'd1;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      rd_hi[c] = bus_rd && bus_addr == 3'(2 + 2 * c);
      rd_lo[c] = bus_rd && bus_addr == 3'(3 + 2 * c);
    end
  end

  assign take = det & ~rd_hi & (~lock | rd_lo);

  always_ff @(posedge clk) begin
    for (int c = 0; c < 2; c++)
      if (take[c]) cap[c] <= tcnt + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= '0;
      lock <= '0;
      arm  <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (rd_hi[c])      lock[c] <= 1'b1;
        else if (rd_lo[c]) lock[c] <= 1'b0;

        if (rd_lo[c])                arm[c] <= 1'b0;
        else if (rd_st && flag[c])   arm[c] <= 1'b1;

        if (take[c])                 flag[c] <= 1'b1;
        else if (rd_lo[c] && arm[c]) flag[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {5'b0, rise_sel, ie};
      3'd1:    bus_rdata = {6'b0, flag};
      3'd2:    bus_rdata = cap[0][15:8];
      3'd3:    bus_rdata = cap[0][7:0];
      3'd4:    bus_rdata = cap[1][15:8];
      3'd5:    bus_rdata = cap[1][7:0];
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq = ie & |flag;
endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ie,
  input logic        irq,
  input logic        bus_rd,
  input logic [2:0]  bus_addr,
  input logic [1:0]  flag,
  input logic [1:0]  lock,
  input logic [1:0]  det,
  input logic [1:0]  take,
  input logic [15:0] cap0,
  input logic [15:0] cap1
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flag == 2'b00 && !irq && lock == 2'b00));

  a_r5_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  a_r5_flag0_by_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[0]) |-> $past(take[0]));

  a_r5_flag1_by_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[1]) |-> $past(take[1]));

  a_r7_ch0_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock[0] && !(bus_rd && bus_addr == 3'd3)) |=> $stable(cap0));

  a_r7_ch1_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock[1] && !(bus_rd && bus_addr == 3'd5)) |=> $stable(cap1));

  a_r9_ch0_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap0) |-> $past(det[0]));

  a_r9_ch1_moves_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap1) |-> $past(det[1]));
endmodule

bind tcap_unit tcap_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ie(ie), .irq(irq), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .flag(flag), .lock(lock), .det(det), .take(take),
  .cap0(cap[0]), .cap1(cap[1])
);

// File: tb/test_tcap_unit.sv
`timescale 1ns/1ps
module test_tcap_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cap_pin = 2'b00;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int vectors = 0;
  int errors = 0;
  int ecount = 0;
  logic [15:0] exp_q[$];
  logic [15:0] held;
  logic [7:0]  rb;

  tcap_unit i_tcap_unit (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic drive_pin(input int ch, input logic v, input bit expect_cap);
    @(negedge clk);
    cap_pin[ch] = v;
    if (expect_cap) exp_q.push_back(16'((ecount + 2) / 4 + 1));
  endtask

  task automatic read_cap(input int ch, input string req);
    logic [7:0] hi, lo;
    logic [15:0] e;
    bus_read(3'(2 + 2 * ch), hi);
    bus_read(3'(3 + 2 * ch), lo);
    e = exp_q.pop_front();
    check(req, {hi, lo}, e);
    held = e;
  endtask

  task automatic check_status(input logic [1:0] exp, input string req);
    bus_read(3'd1, rb);
    check(req, {8'h00, rb}, {14'b0, exp});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] hi, lo;
    logic [15:0] e;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    bus_read(3'd0, rb); check("R1 ctrl", {8'h00, rb}, 16'h0000);
    check_status(2'b00, "R1 status");
    #2 check("R1 irq", {15'b0, irq}, 16'h0000);

    bus_write(3'd0, 8'h03);
    bus_read(3'd0, rb); check("R4 ctrl readback", {8'h00, rb}, 16'h0003);

    idle(5);
    drive_pin(0, 1'b1, 1'b1);
    idle(4);
    #2 check("R5 irq set", {15'b0, irq}, 16'h0001);
    check_status(2'b01, "R5 flag0");
    read_cap(0, "R3 R2 first capture");
    check_status(2'b00, "R8 flag0 cleared");
    #2 check("R8 irq low", {15'b0, irq}, 16'h0000);

    drive_pin(0, 1'b0, 1'b0);
    idle(5);
    check_status(2'b00, "R4 falling ignored ch0");
    drive_pin(1, 1'b1, 1'b0);
    idle(5);
    check_status(2'b00, "R4 rising ignored ch1");
    drive_pin(1, 1'b0, 1'b1);
    idle(4);
    check_status(2'b10, "R10 only flag1");
    read_cap(1, "R4 R10 ch1 capture");
    check_status(2'b00, "R8 flag1 cleared");

    drive_pin(0, 1'b1, 1'b0);
    idle(6);
    drive_pin(0, 1'b0, 1'b0);
    idle(3);
    drive_pin(0, 1'b1, 1'b1);
    idle(4);
    check_status(2'b01, "R6 flag still set");
    read_cap(0, "R6 R2 latest overwrites");

    drive_pin(0, 1'b0, 1'b0);
    idle(3);
    drive_pin(0, 1'b1, 1'b1);
    idle(4);
    e = exp_q.pop_front();
    bus_read(3'd2, hi);
    check("R7 high byte", {8'h00, hi}, {8'h00, e[15:8]});
    drive_pin(0, 1'b0, 1'b0);
    idle(2);
    drive_pin(0, 1'b1, 1'b0);
    idle(5);
    bus_read(3'd3, lo);
    check("R7 low byte coherent", {8'h00, lo}, {8'h00, e[7:0]});
    exp_q.push_back(e);
    read_cap(0, "R7 blocked edge dropped");
    drive_pin(0, 1'b0, 1'b0);
    idle(3);
    drive_pin(0, 1'b1, 1'b1);
    idle(4);
    read_cap(0, "R7 unblocked capture");

    bus_write(3'd0, 8'h02);
    #2 check("R5 irq gated off", {15'b0, irq}, 16'h0000);
    bus_write(3'd0, 8'h03);
    #2 check("R5 irq gated on", {15'b0, irq}, 16'h0001);

    bus_write(3'd2, 8'hFF);
    bus_write(3'd3, 8'hFF);
    exp_q.push_back(held);
    read_cap(0, "R9 write ignored");

    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check_status(2'b00, "R1 status after reset");
    bus_read(3'd0, rb); check("R1 ctrl after reset", {8'h00, rb}, 16'h0000);
    exp_q.push_back(held);
    read_cap(0, "R9 kept through reset");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule